// File: doc/BRIEF.md
# Nibble-Serial Two-Pass Adder

This block forms a sum twice the width of its only adder by running that adder twice. A start strobe captures two operands and a carry-in. The next cycle adds the low halves and keeps the partial result and its carry in internal latches. The cycle after that adds the high halves, using the latched carry as their carry-in. In that same cycle the low partial result and the new high result are written together to the result register.

The block raises a done strobe for one cycle when the result is ready. The sum, the final carry and the half carry (the carry between the two halves) stay on the outputs until the next operation finishes. A start that arrives while an operation is running is dropped. One operation can therefore be accepted every three cycles, and a start held high keeps the unit fully busy.

The slice width `NIB_W` is a parameter. Each operand is `2*NIB_W` bits wide, so the default of 4 gives an 8-bit adder built from a 4-bit slice.

Top module: `nibble_serial_adder`

## Requirements
- R1: While `rst` is high and after it is released, `sum`, `carryOut`, `halfCarry` and `done` are all 0 until the first operation completes.
- R2: A `start` sampled high at a clock edge while the unit is idle is accepted. `opA`, `opB` and `carryIn` are sampled at that edge only, and later changes to them do not affect that operation.
- R3: If `start` is accepted at edge n, `done` is high from edge n+2 to edge n+3, and it is high for exactly one cycle.
- R4: When `done` is high, `sum` equals the low `2*NIB_W` bits of opA + opB + carryIn, using the values sampled at acceptance.
- R5: When `done` is high, `carryOut` equals bit `2*NIB_W` of that total.
- R6: When `done` is high, `halfCarry` equals bit `NIB_W` of opA[NIB_W-1:0] + opB[NIB_W-1:0] + carryIn, which is the carry passed from the low pass to the high pass.
- R7: A `start` sampled high on the two edges after acceptance is ignored. It produces no extra `done` and does not change the result.
- R8: `sum`, `carryOut` and `halfCarry` change only in the cycle in which `done` is high, and they hold their values between done pulses.
- R9: A `start` on the edge that ends the `done` cycle is accepted. With `start` held high, a result completes every three cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new addition |
| opA | input | 2*NIB_W | First operand |
| opB | input | 2*NIB_W | Second operand |
| carryIn | input | 1 | Carry into the low pass |
| sum | output | 2*NIB_W | Registered sum |
| carryOut | output | 1 | Carry out of the high pass |
| halfCarry | output | 1 | Carry out of the low pass |
| done | output | 1 | One-cycle result-valid strobe |

## Verification
The bench builds the adder with `NIB_W = 3`. That makes the operands 6 bits wide, so every operand pair can be run with both carry-in values within the cycle budget. This covers every carry chain, including the ones that only ripple across the boundary between the slices through the latched carry. A further phase holds `start` high and changes the operands during each operation. This reaches the ignored-start case, back-to-back acceptance and the rule that operands are sampled only once.

// File: rtl/nsa_pkg.sv
package nsa_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadOps;   // capture operands and carry-in
    logic addLow;    // low pass through the shared slice
    logic addHigh;   // high pass and result write
  } nsaCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } nsaState_t;
endpackage

// File: rtl/nsa_slice_adder.sv
module nsa_slice_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] total;

  always_comb begin
    total = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    s     = total[W-1:0];
    co    = total[W];
  end
endmodule

// File: rtl/nsa_control.sv
module nsa_control
  import nsa_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output nsaCtl_t ctl,
  output logic    done
);
  nsaState_t state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        ctl.loadOps = start;
        if (start) stateNext = ST_LOW;
      end
      ST_LOW: begin
        ctl.addLow = 1'b1;
        stateNext  = ST_HIGH;
      end
      ST_HIGH: begin
        ctl.addHigh = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.addHigh;
    end
  end
endmodule

// File: rtl/nsa_datapath.sv
module nsa_datapath
  import nsa_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  nsaCtl_t            ctl,
  input  logic [2*NIB_W-1:0] opA,
  input  logic [2*NIB_W-1:0] opB,
  input  logic               carryIn,
  output logic [2*NIB_W-1:0] sum,
  output logic               carryOut,
  output logic               halfCarry
);
  localparam int SLICES = 2;
  localparam int DATA_W = SLICES * NIB_W;

  // operand latches, kept as one entry per half (index 0 is the low half)
  logic [NIB_W-1:0] aLat [SLICES];
  logic [NIB_W-1:0] bLat [SLICES];
  logic             cinLat;

  for (genvar g = 0; g < SLICES; g++) begin : g_opLatch
    always_ff @(posedge clk) begin
      if (rst) begin
        aLat[g] <= '0;
        bLat[g] <= '0;
      end else if (ctl.loadOps) begin
        aLat[g] <= opA[g*NIB_W +: NIB_W];
        bLat[g] <= opB[g*NIB_W +: NIB_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cinLat <= 1'b0;
    else if (ctl.loadOps) cinLat <= carryIn;
  end

  // select the inputs of the shared slice
  logic [NIB_W-1:0] sliceA, sliceB, sliceS;
  logic             sliceCi, sliceCo;
  logic [NIB_W-1:0] lowLatch;
  logic             midCarry;

  always_comb begin
    sliceA  = ctl.addHigh ? aLat[1] : aLat[0];
    sliceB  = ctl.addHigh ? bLat[1] : bLat[0];
    sliceCi = ctl.addHigh ? midCarry : cinLat;
  end

  nsa_slice_adder #(.W(NIB_W)) u_slice (
    .a  (sliceA),
    .b  (sliceB),
    .ci (sliceCi),
    .s  (sliceS),
    .co (sliceCo)
  );

  // low pass result and the carry between the halves
  always_ff @(posedge clk) begin
    if (rst) begin
      lowLatch <= '0;
      midCarry <= 1'b0;
    end else if (ctl.addLow) begin
      lowLatch <= sliceS;
      midCarry <= sliceCo;
    end
  end

  // both halves written to the result in the high pass
  logic [DATA_W-1:0] sumReg;
  logic              coReg, hcReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumReg <= '0;
      coReg  <= 1'b0;
      hcReg  <= 1'b0;
    end else if (ctl.addHigh) begin
      sumReg <= {sliceS, lowLatch};
      coReg  <= sliceCo;
      hcReg  <= midCarry;
    end
  end

  assign sum       = sumReg;
  assign carryOut  = coReg;
  assign halfCarry = hcReg;
endmodule

// File: rtl/nibble_serial_adder.sv
module nibble_serial_adder
  import nsa_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [2*NIB_W-1:0] opA,
  input  logic [2*NIB_W-1:0] opB,
  input  logic               carryIn,
  output logic [2*NIB_W-1:0] sum,
  output logic               carryOut,
  output logic               halfCarry,
  output logic               done
);
  nsaCtl_t ctl;

  nsa_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  nsa_datapath #(.NIB_W(NIB_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .sum       (sum),
    .carryOut  (carryOut),
    .halfCarry (halfCarry)
  );
endmodule

// File: rtl/nsa_checker.sv
module nsa_checker #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [2*NIB_W-1:0] opA,
  input logic [2*NIB_W-1:0] opB,
  input logic               carryIn,
  input logic [2*NIB_W-1:0] sum,
  input logic               carryOut,
  input logic               halfCarry,
  input logic               done
);
  localparam int DATA_W = 2 * NIB_W;

  // three-deep history of the inputs
  logic [DATA_W-1:0] aHist [3];
  logic [DATA_W-1:0] bHist [3];
  logic [2:0]        cHist, sHist;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        aHist[i] <= '0;
        bHist[i] <= '0;
      end
      cHist <= '0;
      sHist <= '0;
    end else begin
      aHist[0] <= opA;
      bHist[0] <= opB;
      aHist[1] <= aHist[0];
      bHist[1] <= bHist[0];
      aHist[2] <= aHist[1];
      bHist[2] <= bHist[1];
      cHist    <= {cHist[1:0], carryIn};
      sHist    <= {sHist[1:0], start};
    end
  end

  logic [DATA_W:0] fullRef;
  logic [NIB_W:0]  lowRef;

  always_comb begin
    fullRef = {1'b0, aHist[2]} + {1'b0, bHist[2]} + {{DATA_W{1'b0}}, cHist[2]};
    lowRef  = {1'b0, aHist[2][NIB_W-1:0]} + {1'b0, bHist[2][NIB_W-1:0]}
            + {{NIB_W{1'b0}}, cHist[2]};
  end

  assert_done_after_start_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> sHist[2]);

  assert_done_gap_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done ##1 !done);

  assert_sum_value_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> sum == fullRef[DATA_W-1:0]);

  assert_carry_out_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> carryOut == fullRef[DATA_W]);

  assert_half_carry_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> halfCarry == lowRef[NIB_W]);

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (rst)
    !done |=> (done || $stable(sum)));
endmodule

bind nibble_serial_adder nsa_checker #(.NIB_W(NIB_W)) u_nsaChecker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .sum       (sum),
  .carryOut  (carryOut),
  .halfCarry (halfCarry),
  .done      (done)
);

// File: tb/tb_nibble_serial_adder.sv
`timescale 1ns/1ps
module tb_nibble_serial_adder;
  localparam int NIB_W  = 3;
  localparam int DATA_W = 2 * NIB_W;
  localparam int MAXV   = 1 << DATA_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic [DATA_W-1:0] opA, opB;
  logic              carryIn;
  logic [DATA_W-1:0] sum;
  logic              carryOut, halfCarry, done;

  int testsRun   = 0;
  int testsFail  = 0;
  int cycleCount = 0;
  string phase   = "R1 reset";

  always #5 clk = ~clk;

  nibble_serial_adder #(.NIB_W(NIB_W)) dut (
    .clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .carryIn(carryIn), .sum(sum), .carryOut(carryOut),
    .halfCarry(halfCarry), .done(done)
  );

  // behavioural reference: a countdown of busy cycles and a pending result
  int busyLeft = 0;
  int pendTotal = 0;
  int pendLow = 0;
  int expSum = 0;
  int expCo = 0;
  int expHc = 0;
  int expDone = 0;

  always @(posedge clk) begin
    if (rst) begin
      busyLeft <= 0; expSum <= 0; expCo <= 0; expHc <= 0; expDone <= 0;
    end else begin
      expDone <= 0;
      if (busyLeft == 0) begin
        if (start) begin
          busyLeft  <= 2;
          pendTotal <= int'(opA) + int'(opB) + int'(carryIn);
          pendLow   <= (int'(opA) % (1 << NIB_W)) + (int'(opB) % (1 << NIB_W)) + int'(carryIn);
        end
      end else begin
        busyLeft <= busyLeft - 1;
        if (busyLeft == 1) begin
          expDone <= 1;
          expSum  <= pendTotal % MAXV;
          expCo   <= (pendTotal / MAXV) % 2;
          expHc   <= (pendLow >> NIB_W) % 2;
        end
      end
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      testsRun++; testsFail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycleCount);
      finishRun();
    end
    testsRun += 4;
    if (int'(done) != expDone) begin
      testsFail++;
      $display("FAIL R3 [%s] done actual %0d expected %0d", phase, done, expDone);
    end
    if (int'(sum) != expSum) begin
      testsFail++;
      $display("FAIL R4 [%s] sum actual %0d expected %0d", phase, sum, expSum);
    end
    if (int'(carryOut) != expCo) begin
      testsFail++;
      $display("FAIL R5 [%s] carryOut actual %0d expected %0d", phase, carryOut, expCo);
    end
    if (int'(halfCarry) != expHc) begin
      testsFail++;
      $display("FAIL R6 [%s] halfCarry actual %0d expected %0d", phase, halfCarry, expHc);
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; opA = '0; opB = '0; carryIn = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset values are compared by the per-cycle monitor, also explicitly here
    testsRun++;
    if (sum != 0 || carryOut || halfCarry || done) begin
      testsFail++;
      $display("FAIL R1 reset outputs actual %0d/%0d/%0d/%0d expected 0/0/0/0",
               sum, carryOut, halfCarry, done);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4 R5 R6 exhaustive, with R2 operand scrambling after acceptance
    phase = "R4 exhaustive, R2 scramble";
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < MAXV; a++) begin
        for (int b = 0; b < MAXV; b++) begin
          start = 1'b1; opA = DATA_W'(a); opB = DATA_W'(b); carryIn = c[0];
          @(negedge clk);
          start = 1'b0; opA = ~DATA_W'(a); opB = DATA_W'(a ^ b); carryIn = ~c[0];
          @(negedge clk);
          @(negedge clk);
        end
      end
    end
    start = 1'b0;
    repeat (3) @(negedge clk);

    // R7 R9: start held high, operands change every cycle
    phase = "R7 R9 start held";
    for (int k = 0; k < 60; k++) begin
      start = 1'b1;
      opA = DATA_W'(k * 7 + 3);
      opB = DATA_W'(MAXV - 1 - k);
      carryIn = k[1];
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);

    // R8: results held while idle with moving operands
    phase = "R8 idle hold";
    for (int k = 0; k < 10; k++) begin
      opA = DATA_W'(k * 5); opB = DATA_W'(k * 11); carryIn = k[0];
      @(negedge clk);
    end
    finishRun();
  end
endmodule